// File: doc/BRIEF.md
# Asynchronous 8-bit I/O-mapped register slave

This block sits on an ISA-compatible stacking bus and answers 8-bit I/O-port read and write cycles that fall inside a fixed, aligned address window. The bus strobes, the address lines and the address-enable line have no timing relation to the block's clock. The block brings the strobes and address-enable into its clock domain through a synchronizer chain before it acts on them. A bus write stores the data byte into one of the window's registers when the write strobe is released. A bus read places the addressed register on the data bus. The output enable is asserted only while a qualified read is in progress.

On the chip side, a clocked local port reads and writes the same register bank. Local logic can therefore publish status bytes for the host and consume the command bytes that the host writes. The window base and its size are elaboration parameters. They take the place of the jumper settings that a board would otherwise carry.

Top module: `io8_slave`

## Requirements
- R1: Out of reset the data-bus output enable is low and every register in the bank reads as 00h on the local port.
- R2: A write cycle whose address lies in the window (default 300h to 31Fh, register index = address bits 4:0) with address-enable low stores the data byte into the indexed register. The store happens on the rising edge of the synchronized write strobe, and the new value can be read on the local port afterwards.
- R3: A write cycle with address-enable high, or with an address outside the window (for example 2FFh or 320h), changes no register.
- R4: While a qualified read is held (address in the window, address-enable low, read strobe low), the output enable is high and the data output carries the indexed register. Both are valid no later than the third clock edge after the read strobe falls.
- R5: The output enable stays low for a read with address-enable high or with an address outside the window. It returns low within three clock edges after the read strobe rises.
- R6: A local write stores its byte at the next clock edge, and a later bus read returns that byte. A local read returns the indexed register one clock edge after the index is presented.
- R7: When a bus write and a local write land on the same register at the same clock edge, the register takes the bus byte.
- R8: A write strobe held low for many cycles changes nothing while it stays low. It produces exactly one store, at its release.
- R9: Elaboration rejects a synchronizer shorter than two stages, a base that is not aligned to the window size, and a window that overlaps the fixed serial-port ranges 2F8h-2FFh and 3F8h-3FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 10 | I/O address lines, asynchronous |
| bus_data_in | input | 8 | Data lines as seen by the receiver |
| bus_data_out | output | 8 | Byte to drive onto the data lines |
| bus_data_oe | output | 1 | Drive enable for the data lines |
| bus_rd_n | input | 1 | Active-low read strobe, asynchronous |
| bus_wr_n | input | 1 | Active-low write strobe, asynchronous |
| bus_aen | input | 1 | Address enable; high marks a non-I/O cycle |
| loc_addr | input | 5 | Local register index |
| loc_we | input | 1 | Local write enable |
| loc_wdata | input | 8 | Local write byte |
| loc_rdata | output | 8 | Local read byte, registered |

## Verification
The hardest situation to reach is a bus write and a local write that hit the same register at the same clock edge. The bus store occurs only after the released strobe has crossed the synchronizer. The bench changes the strobes half a clock away from the sampling edges, so the store edge is fixed at the third edge after release. The collision task raises the local write enable for exactly that edge. Long-held write strobes and reads with address-enable high or with addresses just outside the window are each driven by their own task. A randomized sequence checks the whole bank against a reference model at the end.

// File: rtl/io8_pkg.sv
package io8_pkg;

   typedef logic [7:0] byte_t;

   // True when [base, base+span-1] intersects [lo, hi].
   function automatic bit range_overlaps(int unsigned base, int unsigned span,
                                         int unsigned lo, int unsigned hi);
      return (base <= hi) && ((base + span - 1) >= lo);
   endfunction

   localparam int unsigned SER_A_LO = 'h2F8;
   localparam int unsigned SER_A_HI = 'h2FF;
   localparam int unsigned SER_B_LO = 'h3F8;
   localparam int unsigned SER_B_HI = 'h3FF;

endpackage

// File: rtl/io8_sync.sv
module io8_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/io8_decode.sv
module io8_decode #(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WIN_BITS = 5,
   parameter logic [ADDR_W-1:0] BASE = 10'h300
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_data_in,
   input  logic                rd_s,
   input  logic                wr_s,
   input  logic                aen_s,
   input  logic [DATA_W-1:0]   rd_byte,
   output logic [WIN_BITS-1:0] rd_idx,
   output logic [DATA_W-1:0]   data_out,
   output logic                data_oe,
   output logic                commit,
   output logic [WIN_BITS-1:0] cap_idx,
   output logic [DATA_W-1:0]   cap_data
);

   logic hit_now;
   logic wr_prev;
   logic cap_ok;

   assign hit_now = (bus_addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
   assign rd_idx  = bus_addr[WIN_BITS-1:0];

   // Address, data and qualification are sampled on every cycle the
   // synchronized write strobe is low; the last sample is committed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_idx  <= '0;
         cap_data <= '0;
         cap_ok   <= 1'b0;
         wr_prev  <= 1'b1;
      end else begin
         wr_prev <= wr_s;
         if (!wr_s) begin
            cap_idx  <= bus_addr[WIN_BITS-1:0];
            cap_data <= bus_data_in;
            cap_ok   <= hit_now && !aen_s;
         end
      end
   end

   assign commit = wr_s && !wr_prev && cap_ok;

   // Read path: registered enable and byte, so the pins never glitch.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_oe  <= 1'b0;
         data_out <= '0;
      end else begin
         data_oe  <= !rd_s && !aen_s && hit_now;
         data_out <= rd_byte;
      end
   end

endmodule

// File: rtl/io8_regbank.sv
module io8_regbank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 5,
   localparam int unsigned DEPTH = 1 << IDX_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_we,
   input  logic [IDX_W-1:0]             bus_idx,
   input  logic [DATA_W-1:0]            bus_wdata,
   input  logic                         loc_we,
   input  logic [IDX_W-1:0]             loc_idx,
   input  logic [DATA_W-1:0]            loc_wdata,
   input  logic [IDX_W-1:0]             rd_idx,
   output logic [DATA_W-1:0]            rd_byte,
   output logic [DATA_W-1:0]            loc_rdata,
   output logic [DEPTH-1:0][DATA_W-1:0] mem
);

   generate
      for (genvar j = 0; j < DEPTH; j++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[j] <= '0;
            else if (bus_we && (bus_idx == IDX_W'(j)))
               mem[j] <= bus_wdata;
            else if (loc_we && (loc_idx == IDX_W'(j)))
               mem[j] <= loc_wdata;
         end
      end
   endgenerate

   assign rd_byte = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) loc_rdata <= '0;
      else        loc_rdata <= mem[loc_idx];
   end

endmodule

// File: rtl/io8_slave.sv
module io8_slave #(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned WIN_BITS    = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] BASE  = 10'h300,
   localparam int unsigned DEPTH      = 1 << WIN_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_data_in,
   output logic [DATA_W-1:0]   bus_data_out,
   output logic                bus_data_oe,
   input  logic                bus_rd_n,
   input  logic                bus_wr_n,
   input  logic                bus_aen,
   input  logic [WIN_BITS-1:0] loc_addr,
   input  logic                loc_we,
   input  logic [DATA_W-1:0]   loc_wdata,
   output logic [DATA_W-1:0]   loc_rdata
);
   import io8_pkg::*;

   // R9: parameter legality
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("io8_slave: SYNC_STAGES must be at least 2");
      end
      if (WIN_BITS >= ADDR_W) begin : g_bad_win
         $error("io8_slave: window must be smaller than the address space");
      end
      if ((int'(BASE) % DEPTH) != 0) begin : g_bad_align
         $error("io8_slave: BASE must be aligned to the window size");
      end
      if (range_overlaps(int'(BASE), DEPTH, SER_A_LO, SER_A_HI) ||
          range_overlaps(int'(BASE), DEPTH, SER_B_LO, SER_B_HI)) begin : g_clash
         $error("io8_slave: window overlaps a fixed serial-port range");
      end
   endgenerate

   logic                        rd_s, wr_s, aen_s;
   logic                        commit;
   logic [WIN_BITS-1:0]         cap_idx;
   logic [DATA_W-1:0]           cap_data;
   logic [WIN_BITS-1:0]         rd_idx;
   logic [DATA_W-1:0]           rd_byte;
   logic [DEPTH-1:0][DATA_W-1:0] mem;

   io8_sync #(
      .STAGES (SYNC_STAGES),
      .W      (3),
      .RST_VAL(3'b111)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async({bus_rd_n, bus_wr_n, bus_aen}),
      .q      ({rd_s, wr_s, aen_s})
   );

   io8_decode #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .WIN_BITS(WIN_BITS),
      .BASE    (BASE)
   ) dec_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_data_in(bus_data_in),
      .rd_s       (rd_s),
      .wr_s       (wr_s),
      .aen_s      (aen_s),
      .rd_byte    (rd_byte),
      .rd_idx     (rd_idx),
      .data_out   (bus_data_out),
      .data_oe    (bus_data_oe),
      .commit     (commit),
      .cap_idx    (cap_idx),
      .cap_data   (cap_data)
   );

   io8_regbank #(
      .DATA_W(DATA_W),
      .IDX_W (WIN_BITS)
   ) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_we   (commit),
      .bus_idx  (cap_idx),
      .bus_wdata(cap_data),
      .loc_we   (loc_we),
      .loc_idx  (loc_addr),
      .loc_wdata(loc_wdata),
      .rd_idx   (rd_idx),
      .rd_byte  (rd_byte),
      .loc_rdata(loc_rdata),
      .mem      (mem)
   );

endmodule

// File: rtl/io8_slave_chk.sv
module io8_slave_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 5,
   localparam int unsigned DEPTH = 1 << IDX_W
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_data_oe,
   input logic                         rd_s,
   input logic                         aen_s,
   input logic                         commit,
   input logic [IDX_W-1:0]             cap_idx,
   input logic [DATA_W-1:0]            cap_data,
   input logic                         loc_we,
   input logic [IDX_W-1:0]             loc_addr,
   input logic [DATA_W-1:0]            loc_wdata,
   input logic [DEPTH-1:0][DATA_W-1:0] mem
);

   // R5: a released read strobe removes the drive on the next edge
   a_r5_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
      rd_s |=> !bus_data_oe);

   // R5: address-enable high keeps the bus undriven
   a_r5_aen_blocks_oe: assert property (@(posedge clk) disable iff (!rst_n)
      aen_s |=> !bus_data_oe);

   // R2 and R7: a bus store always lands, whatever the local port does
   a_r7_bus_store_wins: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (mem[$past(cap_idx)] == $past(cap_data)));

   // R6: an uncontested local write lands
   a_r6_local_store: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_we && !(commit && (cap_idx == loc_addr)))
         |=> (mem[$past(loc_addr)] == $past(loc_wdata)));

   // R3: with no store request the bank holds
   a_r3_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !loc_we) |=> $stable(mem));

   // R8: one store per strobe release
   a_r8_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

endmodule

bind io8_slave io8_slave_chk #(
   .DATA_W(DATA_W),
   .IDX_W (WIN_BITS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_data_oe(bus_data_oe),
   .rd_s       (rd_s),
   .aen_s      (aen_s),
   .commit     (commit),
   .cap_idx    (cap_idx),
   .cap_data   (cap_data),
   .loc_we     (loc_we),
   .loc_addr   (loc_addr),
   .loc_wdata  (loc_wdata),
   .mem        (mem)
);

// File: tb/io8_slave_tb_top.sv
`timescale 1ns/1ps
module io8_slave_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] bus_addr = '0;
   logic [7:0] bus_data_in = '0;
   logic [7:0] bus_data_out;
   logic       bus_data_oe;
   logic       bus_rd_n = 1'b1;
   logic       bus_wr_n = 1'b1;
   logic       bus_aen = 1'b1;
   logic [4:0] loc_addr = '0;
   logic       loc_we = 1'b0;
   logic [7:0] loc_wdata = '0;
   logic [7:0] loc_rdata;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [32];
   bit done = 0;

   always #2 clk = ~clk;

   io8_slave dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_data_in(bus_data_in),
      .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_aen(bus_aen),
      .loc_addr(loc_addr), .loc_we(loc_we), .loc_wdata(loc_wdata),
      .loc_rdata(loc_rdata)
   );

   function automatic bit in_win(logic [9:0] a);
      return a[9:5] == 5'b11000;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [9:0] a, logic [7:0] d, logic aen, int low_cycles);
      @(negedge clk);
      bus_addr = a; bus_data_in = d; bus_aen = aen;
      @(negedge clk); bus_wr_n = 1'b0;
      repeat (low_cycles) @(negedge clk);
      bus_wr_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_aen = 1'b1;
      if (in_win(a) && !aen) model[a[4:0]] = d;
   endtask

   task automatic loc_read_check(logic [4:0] idx, logic [7:0] exp, string req);
      @(negedge clk); loc_addr = idx;
      @(negedge clk);
      check(loc_rdata == exp, req, loc_rdata, exp);
   endtask

   task automatic bus_read_check(logic [9:0] a, logic aen, bit exp_oe,
                                 logic [7:0] exp, string req);
      @(negedge clk);
      bus_addr = a; bus_aen = aen;
      @(negedge clk); bus_rd_n = 1'b0;
      repeat (4) @(negedge clk);
      check(bus_data_oe == exp_oe, req, bus_data_oe, exp_oe);
      if (exp_oe) check(bus_data_out == exp, req, bus_data_out, exp);
      bus_rd_n = 1'b1;
      repeat (4) @(negedge clk);
      check(bus_data_oe == 1'b0, "R5 release", bus_data_oe, 0);
      bus_aen = 1'b1;
   endtask

   task automatic loc_write(logic [4:0] idx, logic [7:0] d);
      @(negedge clk);
      loc_addr = idx; loc_wdata = d; loc_we = 1'b1;
      @(negedge clk); loc_we = 1'b0;
      model[idx] = d;
   endtask

   task automatic t_reset();
      check(bus_data_oe == 1'b0, "R1 oe in reset", bus_data_oe, 0);
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 32; i++) loc_read_check(5'(i), 8'h00, "R1 bank zero");
   endtask

   task automatic t_write_in_window();
      bus_write(10'h300, 8'hA5, 1'b0, 6);
      loc_read_check(5'd0, 8'hA5, "R2 write 300h");
      bus_write(10'h31F, 8'h3C, 1'b0, 6);
      loc_read_check(5'd31, 8'h3C, "R2 write 31Fh");
   endtask

   task automatic t_write_ignored();
      bus_write(10'h2FF, 8'h11, 1'b0, 6);   // outside, aliases index 31
      loc_read_check(5'd31, 8'h3C, "R3 below window");
      bus_write(10'h320, 8'h22, 1'b0, 6);   // outside, aliases index 0
      loc_read_check(5'd0, 8'hA5, "R3 above window");
      bus_write(10'h305, 8'h33, 1'b1, 6);   // AEN high
      loc_read_check(5'd5, 8'h00, "R3 aen high");
   endtask

   task automatic t_read();
      bus_read_check(10'h300, 1'b0, 1'b1, 8'hA5, "R4 read 300h");
      bus_read_check(10'h31F, 1'b0, 1'b1, 8'h3C, "R4 read 31Fh");
      bus_read_check(10'h320, 1'b0, 1'b0, 8'h00, "R5 read outside");
      bus_read_check(10'h300, 1'b1, 1'b0, 8'h00, "R5 read aen high");
   endtask

   task automatic t_local();
      loc_write(5'd9, 8'h5E);
      loc_read_check(5'd9, 8'h5E, "R6 local readback");
      bus_read_check(10'h309, 1'b0, 1'b1, 8'h5E, "R6 bus sees local");
   endtask

   task automatic t_collision();
      @(negedge clk);
      bus_addr = 10'h30C; bus_data_in = 8'hB7; bus_aen = 1'b0;
      @(negedge clk); bus_wr_n = 1'b0;
      repeat (5) @(negedge clk);
      bus_wr_n = 1'b1;
      // store edge is the third posedge after release
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      loc_addr = 5'd12; loc_wdata = 8'h4D; loc_we = 1'b1;
      @(negedge clk); loc_we = 1'b0;
      repeat (3) @(negedge clk);
      bus_aen = 1'b1;
      model[12] = 8'hB7;
      loc_read_check(5'd12, 8'hB7, "R7 bus wins collision");
   endtask

   task automatic t_long_strobe();
      @(negedge clk);
      bus_addr = 10'h314; bus_data_in = 8'hE1; bus_aen = 1'b0;
      loc_addr = 5'd20;
      @(negedge clk); bus_wr_n = 1'b0;
      repeat (40) @(negedge clk);
      check(loc_rdata == 8'h00, "R8 no store while low", loc_rdata, 0);
      bus_wr_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_aen = 1'b1;
      model[20] = 8'hE1;
      loc_read_check(5'd20, 8'hE1, "R8 store at release");
   endtask

   task automatic t_random();
      for (int n = 0; n < 40; n++) begin
         logic [9:0] a;
         a = 10'h2E0 + 10'($urandom_range(0, 95));
         bus_write(a, 8'($urandom), ($urandom_range(0, 3) == 0), 2 + $urandom_range(0, 6));
      end
      for (int i = 0; i < 32; i++) loc_read_check(5'(i), model[i], "R3 R2 random sweep");
      for (int i = 0; i < 32; i += 7)
         bus_read_check(10'h300 + 10'(i), 1'b0, 1'b1, model[i], "R4 random read");
   endtask

   initial begin
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      t_write_in_window();
      t_write_ignored();
      t_read();
      t_local();
      t_collision();
      t_long_strobe();
      t_random();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule